// File: doc/BRIEF.md
# Bidirectional Row/Column Scanner with Centred Black Frame

This block is a cycle-level behavioural model of the scan logic of an active-matrix display of 804 columns by 604 rows. A vertical scan register picks one gate line at a time. A horizontal scan register picks one group of six adjacent columns at a time, and all six dots of that group are sampled together. Either register can scan in either direction. All panel timing inputs are sampled on a fast system clock. Level changes on the scan clocks are turned into single-cycle step events inside the block.

A three-bit area code picks one of four active windows. The window always stays centred on the matrix. The scan start positions move with the window, so one line and one frame need fewer steps in the smaller modes. Every dot of the strobed group that lies outside the window, or on a row outside it, is flagged as forced to black. The enable input gates the row select without disturbing the scan position.

Top module: `bidir_scan_frame`

## Requirements
- R1: While reset is asserted and on the cycle after it, no gate line is selected, no column group is strobed, and all six black flags are 1.
- R2: `area_sel` (bit 2 = first mode pin, bit 0 = third) selects the window. 3'b001 gives 804x604, columns 0..803, rows 0..603, groups 0..133. 3'b010 gives 762x572, columns 21..782, rows 16..587, groups 3..130. 3'b011 gives 644x484, columns 80..723, rows 60..543, groups 13..120. 3'b100 gives 644x404, columns 80..723, rows 100..503, groups 13..120.
- R3: With `v_dir_down`=1, a change of `v_clk` (rising or falling) while `v_start`=1 loads the window's first row. Each later change of `v_clk` moves the selection to the next higher row index. The register updates on the first clock edge that sees the change.
- R4: With `v_dir_down`=0, a start loads the window's last row, and each later change of `v_clk` moves the selection to the next lower row index.
- R5: At most one bit of `gate_sel` is high, and only while `gate_en` is high. Dropping `gate_en` clears `gate_sel` in the same cycle and does not move the scan position.
- R6: With `h_dir_right`=1, a rising edge on `h_clk_a` or `h_clk_b` while `h_start`=1 loads the window's first group. Each later rising edge on either clock strobes the next higher group. At most one bit of `grp_strobe` is high.
- R7: With `h_dir_right`=0, a start loads the window's last group, and each later step strobes the next lower group.
- R8: `dot_black[k]` is 1 when the dot at column 6*g+k (g = strobed group) lies outside the window's columns, when the selected row lies outside the window's rows, or when no row or no group is active.
- R9: A scan that steps past index 0 or past the last index of its register goes inactive and does not wrap around.
- R10: In a cycle in which `v_clk` has not changed, the vertical scan position does not change.
- R11: Any area code not listed in R2 behaves as 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| v_start | input | 1 | Vertical start pulse |
| v_clk | input | 1 | Vertical scan clock; both edges step |
| gate_en | input | 1 | Gate line enable |
| h_start | input | 1 | Horizontal start pulse |
| h_clk_a | input | 1 | Horizontal scan clock, phase A |
| h_clk_b | input | 1 | Horizontal scan clock, phase B |
| h_dir_right | input | 1 | 1: columns ascend, 0: descend |
| v_dir_down | input | 1 | 1: rows ascend, 0: descend |
| area_sel | input | 3 | Active window code |
| gate_sel | output | 604 | One-hot gate line select |
| grp_strobe | output | 134 | One-hot column group sample strobe |
| dot_black | output | 6 | Forced-black flag for each dot of the strobed group |

## Verification
The bound assertions check four things on every cycle: row selection stays at most one-hot and needs enable, group strobing stays at most one-hot, the vertical position holds when its clock is idle, and no dot is blanked in full-size mode. They also check that a reverse full-size vertical start lands on the last row. Only the bench's scenarios can show the centred window edges. These are the start rows and groups of each mode in both directions, the exact black-flag boundaries of the partly covered border groups, the rows just outside each window, the fallback of undefined codes, and the run-off at the ends of both registers.

// File: rtl/scan_pkg.sv
// Shared geometry for the scan model: matrix size, group width and the
// centred active window computed for each area code.
// Assumes window widths and heights are even so the margins are symmetric.
package scan_pkg;
    localparam int COLS    = 804;
    localparam int ROWS    = 604;
    localparam int GRP     = 6;
    localparam int GROUPS  = (COLS + GRP - 1) / GRP;
    localparam int CW      = $clog2(COLS);
    localparam int RW      = $clog2(ROWS);
    localparam int GW      = $clog2(GROUPS);

    localparam int W_MID    = 762;
    localparam int H_MID    = 572;
    localparam int W_NARROW = 644;
    localparam int H_TALL   = 484;
    localparam int H_SHORT  = 404;

    typedef logic [CW-1:0] col_t;
    typedef logic [RW-1:0] row_t;
    typedef logic [GW-1:0] grp_t;

    typedef struct packed {
        col_t col_lo;
        col_t col_hi;
        row_t row_lo;
        row_t row_hi;
        grp_t grp_lo;
        grp_t grp_hi;
    } window_t;

    // Maps an area code to its centred window; unlisted codes fall back to full size.
    function automatic window_t area_window(input logic [2:0] code);
        int w;
        int h;
        int cm;
        int rm;
        window_t r;
        case (code)
            3'b010:  begin w = W_MID;    h = H_MID;   end
            3'b011:  begin w = W_NARROW; h = H_TALL;  end
            3'b100:  begin w = W_NARROW; h = H_SHORT; end
            default: begin w = COLS;     h = ROWS;    end
        endcase
        cm = (COLS - w) / 2;
        rm = (ROWS - h) / 2;
        r.col_lo = col_t'(cm);
        r.col_hi = col_t'(cm + w - 1);
        r.row_lo = row_t'(rm);
        r.row_hi = row_t'(rm + h - 1);
        r.grp_lo = grp_t'(cm / GRP);
        r.grp_hi = grp_t'((cm + w - 1) / GRP);
        return r;
    endfunction
endpackage

// File: rtl/scan_axis.sv
// One scan register held as a position plus an active bit.
// A start loads the first or last window position depending on direction;
// each step moves one place and running past either end deactivates.
// Assumes step is a single-cycle pulse.
module scan_axis #(
    parameter int N = 604,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         start,
    input  logic         fwd,
    input  logic [W-1:0] first_pos,
    input  logic [W-1:0] last_pos,
    output logic [W-1:0] pos,
    output logic         valid
);
    localparam logic [W-1:0] TOP = W'(N - 1);

    // Load, advance or retire the scan position on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= '0;
            valid <= 1'b0;
        end else if (step) begin
            if (start) begin
                pos   <= fwd ? first_pos : last_pos;
                valid <= 1'b1;
            end else if (valid) begin
                if (fwd) begin
                    if (pos == TOP) valid <= 1'b0;
                    else            pos   <= pos + 1'b1;
                end else begin
                    if (pos == '0)  valid <= 1'b0;
                    else            pos   <= pos - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/frame_mask.sv
// Computes the forced-black flag for each dot of the strobed column group
// from the current row, the group position and the active window.
// Assumes column indices of the last group stay below 2**CW.
module frame_mask
    import scan_pkg::*;
#(
    parameter int G = GRP
) (
    input  window_t      win,
    input  grp_t         h_pos,
    input  logic         h_valid,
    input  row_t         v_pos,
    input  logic         v_valid,
    output logic [G-1:0] black
);
    logic row_in;
    logic [G-1:0] col_in;
    col_t base;

    // Row test and first column of the strobed group.
    always_comb begin
        row_in = (v_pos >= win.row_lo) && (v_pos <= win.row_hi);
        base   = col_t'(h_pos) * col_t'(G);
    end

    for (genvar k = 0; k < G; k++) begin : g_dot
        col_t col;
        assign col       = base + col_t'(k);
        assign col_in[k] = (col >= win.col_lo) && (col <= win.col_hi);
        assign black[k]  = !(h_valid && v_valid && row_in && col_in[k]);
    end
endmodule

// File: rtl/bidir_scan_frame.sv
// Top of the scan model: edge detection on the panel clocks, the vertical
// and horizontal scan registers, one-hot decode and the black-frame mask.
// Assumes all panel inputs are synchronous to clk and slower than it.
module bidir_scan_frame
    import scan_pkg::*;
#(
    parameter int N_ROWS = ROWS,
    parameter int N_GRPS = GROUPS,
    parameter int G      = GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_start,
    input  logic              v_clk,
    input  logic              gate_en,
    input  logic              h_start,
    input  logic              h_clk_a,
    input  logic              h_clk_b,
    input  logic              h_dir_right,
    input  logic              v_dir_down,
    input  logic [2:0]        area_sel,
    output logic [N_ROWS-1:0] gate_sel,
    output logic [N_GRPS-1:0] grp_strobe,
    output logic [G-1:0]      dot_black
);
    logic    v_clk_q, h_a_q, h_b_q;
    logic    v_step, h_step;
    window_t win;
    row_t    v_pos;
    grp_t    h_pos;
    logic    v_valid, h_valid;

    // Remember last clock levels to detect steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_clk_q <= 1'b0;
            h_a_q   <= 1'b0;
            h_b_q   <= 1'b0;
        end else begin
            v_clk_q <= v_clk;
            h_a_q   <= h_clk_a;
            h_b_q   <= h_clk_b;
        end
    end

    // Step events and window lookup.
    always_comb begin
        v_step = v_clk ^ v_clk_q;
        h_step = (h_clk_a & ~h_a_q) | (h_clk_b & ~h_b_q);
        win    = area_window(area_sel);
    end

    scan_axis #(.N(N_ROWS), .W(RW)) u_vert (
        .clk(clk), .rst_n(rst_n), .step(v_step), .start(v_start),
        .fwd(v_dir_down), .first_pos(win.row_lo), .last_pos(win.row_hi),
        .pos(v_pos), .valid(v_valid)
    );

    scan_axis #(.N(N_GRPS), .W(GW)) u_horz (
        .clk(clk), .rst_n(rst_n), .step(h_step), .start(h_start),
        .fwd(h_dir_right), .first_pos(win.grp_lo), .last_pos(win.grp_hi),
        .pos(h_pos), .valid(h_valid)
    );

    for (genvar i = 0; i < N_ROWS; i++) begin : g_row
        assign gate_sel[i] = gate_en && v_valid && (v_pos == row_t'(i));
    end

    for (genvar j = 0; j < N_GRPS; j++) begin : g_grp
        assign grp_strobe[j] = h_valid && (h_pos == grp_t'(j));
    end

    frame_mask #(.G(G)) u_mask (
        .win(win), .h_pos(h_pos), .h_valid(h_valid),
        .v_pos(v_pos), .v_valid(v_valid), .black(dot_black)
    );
endmodule

// File: rtl/scan_frame_chk.sv
// Property checker for bidir_scan_frame, attached by bind below.
// Assumes default geometry from scan_pkg.
module scan_frame_chk
    import scan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              v_clk,
    input logic              v_start,
    input logic              v_dir_down,
    input logic              gate_en,
    input logic [2:0]        area_sel,
    input logic [ROWS-1:0]   gate_sel,
    input logic [GROUPS-1:0] grp_strobe,
    input logic [GRP-1:0]    dot_black,
    input logic              v_step,
    input row_t              v_pos,
    input logic              v_valid
);
    logic live;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        live <= rst_n;
    end

    a_r5_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_sel));

    a_r5_row_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_sel != '0) |-> gate_en);

    a_r6_single_group: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_strobe));

    a_r10_idle_clock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (v_clk == $past(v_clk))) |=> ($stable(v_pos) && $stable(v_valid)));

    a_r8_full_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((area_sel == 3'b001) && v_valid && (grp_strobe != '0)) |-> (dot_black == '0));

    a_r4_reverse_load_last: assert property (@(posedge clk) disable iff (!rst_n)
        (live && v_step && v_start && !v_dir_down && (area_sel == 3'b001))
        |=> (v_valid && (v_pos == row_t'(ROWS - 1))));
endmodule

bind bidir_scan_frame scan_frame_chk chk_i (
    .clk(clk), .rst_n(rst_n), .v_clk(v_clk), .v_start(v_start),
    .v_dir_down(v_dir_down), .gate_en(gate_en), .area_sel(area_sel),
    .gate_sel(gate_sel), .grp_strobe(grp_strobe), .dot_black(dot_black),
    .v_step(v_step), .v_pos(v_pos), .v_valid(v_valid)
);

// File: tb/bidir_scan_frame_tb_top.sv
module bidir_scan_frame_tb_top;
    import scan_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v_start = 0, v_clk = 0, gate_en = 0, h_start = 0;
    logic h_clk_a = 0, h_clk_b = 0, h_dir_right = 1, v_dir_down = 1;
    logic [2:0] area_sel = 3'b001;
    logic [ROWS-1:0]   gate_sel;
    logic [GROUPS-1:0] grp_strobe;
    logic [GRP-1:0]    dot_black;
    logic h_phase = 1'b0;
    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    bidir_scan_frame dut_i (
        .clk(clk), .rst_n(rst_n), .v_start(v_start), .v_clk(v_clk),
        .gate_en(gate_en), .h_start(h_start), .h_clk_a(h_clk_a),
        .h_clk_b(h_clk_b), .h_dir_right(h_dir_right), .v_dir_down(v_dir_down),
        .area_sel(area_sel), .gate_sel(gate_sel), .grp_strobe(grp_strobe),
        .dot_black(dot_black)
    );

    typedef struct packed {
        logic [2:0] code;
        logic       right;
        logic       down;
        logic [9:0] g_first, g_last, r_first, r_last, c_lo, c_hi;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'b001, 1'b1, 1'b1, 10'd0,  10'd133, 10'd0,   10'd603, 10'd0,  10'd803},
        '{3'b001, 1'b0, 1'b0, 10'd0,  10'd133, 10'd0,   10'd603, 10'd0,  10'd803},
        '{3'b010, 1'b1, 1'b1, 10'd3,  10'd130, 10'd16,  10'd587, 10'd21, 10'd782},
        '{3'b010, 1'b0, 1'b0, 10'd3,  10'd130, 10'd16,  10'd587, 10'd21, 10'd782},
        '{3'b011, 1'b1, 1'b1, 10'd13, 10'd120, 10'd60,  10'd543, 10'd80, 10'd723},
        '{3'b011, 1'b0, 1'b0, 10'd13, 10'd120, 10'd60,  10'd543, 10'd80, 10'd723},
        '{3'b100, 1'b1, 1'b1, 10'd13, 10'd120, 10'd100, 10'd503, 10'd80, 10'd723},
        '{3'b100, 1'b0, 1'b0, 10'd13, 10'd120, 10'd100, 10'd503, 10'd80, 10'd723},
        '{3'b000, 1'b1, 1'b0, 10'd0,  10'd133, 10'd0,   10'd603, 10'd0,  10'd803},
        '{3'b111, 1'b0, 1'b1, 10'd0,  10'd133, 10'd0,   10'd603, 10'd0,  10'd803},
        '{3'b110, 1'b1, 1'b1, 10'd0,  10'd133, 10'd0,   10'd603, 10'd0,  10'd803},
        '{3'b101, 1'b0, 1'b0, 10'd0,  10'd133, 10'd0,   10'd603, 10'd0,  10'd803}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int row_idx(input logic [ROWS-1:0] v);
        int r = -1;
        for (int i = 0; i < ROWS; i++) if (v[i]) r = (r == -1) ? i : -2;
        return r;
    endfunction

    function automatic int grp_idx(input logic [GROUPS-1:0] v);
        int r = -1;
        for (int i = 0; i < GROUPS; i++) if (v[i]) r = (r == -1) ? i : -2;
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic vtoggle();
        v_clk = ~v_clk;
        tick();
    endtask

    task automatic hstep();
        if (h_phase) begin h_clk_a = 0; h_clk_b = 1; end
        else         begin h_clk_a = 1; h_clk_b = 0; end
        h_phase = ~h_phase;
        tick();
    endtask

    task automatic do_reset();
        v_clk = 0; h_clk_a = 0; h_clk_b = 0; h_phase = 0;
        v_start = 0; h_start = 0;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    initial begin
        #(4 * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        gate_en = 1;
        #1;
        // R1: reset state
        check(gate_sel == '0, "R1 rows", row_idx(gate_sel), -1);
        check(grp_strobe == '0, "R1 groups", grp_idx(grp_strobe), -1);
        check(dot_black == 6'h3f, "R1 black", int'(dot_black), 63);

        for (int n = 0; n < NV; n++) begin
            vec_t v = VECS[n];
            int rs, gs, nh, nr, exp_r, exp_g;
            area_sel = v.code; h_dir_right = v.right; v_dir_down = v.down;
            gate_en = 1;
            rs = v.down  ? int'(v.r_first) : int'(v.r_last);
            gs = v.right ? int'(v.g_first) : int'(v.g_last);
            // R2 R3 R4 R11: vertical start position
            v_start = 1; vtoggle(); v_start = 0;
            check(row_idx(gate_sel) == rs, "R3/R4 start row", row_idx(gate_sel), rs);
            // R5: enable gates the row select
            gate_en = 0; #1;
            check(gate_sel == '0, "R5 enable low", row_idx(gate_sel), -1);
            gate_en = 1; #1;
            check(row_idx(gate_sel) == rs, "R5 enable back", row_idx(gate_sel), rs);
            // R6 R7 R8: walk one line
            h_start = 1; hstep(); h_start = 0;
            nh = int'(v.g_last) - int'(v.g_first) + 1;
            for (int i = 0; i < nh; i++) begin
                logic [GRP-1:0] eb;
                exp_g = v.right ? gs + i : gs - i;
                for (int k = 0; k < GRP; k++) begin
                    int c = exp_g * GRP + k;
                    eb[k] = !(c >= int'(v.c_lo) && c <= int'(v.c_hi));
                end
                check(grp_idx(grp_strobe) == exp_g, "R6/R7 group", grp_idx(grp_strobe), exp_g);
                check(dot_black == eb, "R8 border dots", int'(dot_black), int'(eb));
                if (i < nh - 1) hstep();
            end
            // R3 R4: walk the frame, both clock edges step
            nr = int'(v.r_last) - int'(v.r_first) + 1;
            for (int i = 1; i < nr; i++) begin
                vtoggle();
                exp_r = v.down ? rs + i : rs - i;
                check(row_idx(gate_sel) == exp_r, "R3/R4 row walk", row_idx(gate_sel), exp_r);
            end
            // R8 R9: one row past the window
            vtoggle();
            exp_r = v.down ? int'(v.r_last) + 1 : int'(v.r_first) - 1;
            if (exp_r < 0 || exp_r >= ROWS)
                check(gate_sel == '0, "R9 row run-off", row_idx(gate_sel), -1);
            else
                check(row_idx(gate_sel) == exp_r, "R8 outer row", row_idx(gate_sel), exp_r);
            check(dot_black == 6'h3f, "R8 outer row black", int'(dot_black), 63);
        end

        // R10: idle vertical clock keeps the row
        area_sel = 3'b010; v_dir_down = 1; gate_en = 1;
        v_start = 1; vtoggle(); v_start = 0;
        vtoggle();
        repeat (6) tick();
        check(row_idx(gate_sel) == 17, "R10 hold", row_idx(gate_sel), 17);
        vtoggle();
        check(row_idx(gate_sel) == 18, "R10 resume", row_idx(gate_sel), 18);

        // R9: horizontal run-off at the high end
        area_sel = 3'b001; h_dir_right = 1;
        h_start = 1; hstep(); h_start = 0;
        repeat (133) hstep();
        check(grp_idx(grp_strobe) == 133, "R9 last group", grp_idx(grp_strobe), 133);
        hstep();
        check(grp_strobe == '0, "R9 group run-off", grp_idx(grp_strobe), -1);
        hstep();
        check(grp_strobe == '0, "R9 no wrap", grp_idx(grp_strobe), -1);

        // R1: reset in the middle of a scan
        h_start = 1; hstep(); h_start = 0;
        do_reset();
        check(gate_sel == '0 && grp_strobe == '0, "R1 mid-run reset",
              row_idx(gate_sel) + grp_idx(grp_strobe), -2);
        check(dot_black == 6'h3f, "R1 mid-run black", int'(dot_black), 63);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule